// File: doc/BRIEF.md
# Command-Driven Random Number Generator with Automatic Reseed

This block is a register-mapped random number source. Software picks an output size in a mode register, writes a command code into a control register and polls or waits for an interrupt. A generate command fills either four or eight 32-bit output words. When it finishes, a ready bit rises in a status register and stays set until software writes 1 to it. A seed command refreshes the internal key that the output mixing uses.

The block keeps count of the data it has produced. Each 128-bit result counts as one 16-byte unit and each 256-bit result counts as two. Once the count reaches a programmed threshold, the block runs a reseed by itself. Entropy comes from a free-running 32-bit LFSR that stands in for a physical noise source. A rotate-xor-add mix takes the place of a conditioning cipher. A fixed version word lets software identify the block.

Top module: `trng_core`

## Requirements
- R1: The control register at 0x00 takes a command in bits [1:0]: 0 is no-op, 1 generates and 2 seeds. Code 3 is ignored. While a command runs, the register reads back that command, and an automatic reseed reads back as 2. When the block is idle it reads 0.
- R2: Mode register 0x08 bit 3 sets the size of the next generation. A 0 selects 128 bits and refreshes words 0–3. A 1 selects 256 bits and refreshes words 0–7. Word i is read at 0x20+4·i.
- R3: A 128-bit generation leaves words 4–7 unchanged.
- R4: Status register 0x14 sets bit 0 when a generation completes and bit 1 when a seed or automatic reseed completes. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R5: Out of reset the ready bit (status bit 0) is already set. Status bit 1, the control readback, the interrupt and all output words are zero.
- R6: The interrupt output equals enable bit 31 of register 0x10 ANDed with the OR of (enable bit 0 AND status bit 0) and (enable bit 1 AND status bit 1).
- R7: Register 0xF0 always reads 0x46BC, and writes to it have no effect.
- R8: A command written while another command or a reseed is running is ignored.
- R9: Register 0x60 holds N. A 128-bit generation adds one unit to the count and a 256-bit generation adds two. When the count reaches N, an automatic reseed follows the generation and the count restarts from zero. N=0 disables automatic reseed. Writing 0x60 restarts the count.
- R10: Every generation changes each word it refreshes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | Access is a write when high |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | Gated interrupt |

## Verification
The hardest case to reach from the ports is the automatic reseed. It depends on a count that software cannot read, and the count grows by one or two per generation depending on the mode. The bench sweeps both modes against thresholds 1 to 4. For each case it runs six generations in a row and predicts arithmetically after which ones status bit 1 must appear. It also issues a generate command one cycle after a seed command, so the second write lands while the block is busy and its effect must be absent.

// File: rtl/trng_core.sv
module trng_core #(
  parameter int          SEED_CYCLES  = 16,
  parameter logic [31:0] LFSR_INIT    = 32'h1ACE_B00C,
  parameter logic [31:0] KEY_INIT     = 32'h5EED_0001,
  parameter bit          RDY_AT_RESET = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_en,
  input  logic        bus_we,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq
);
  localparam int SCW = $clog2(SEED_CYCLES + 1);
  localparam int CW  = (SCW > 3) ? SCW : 3;
  localparam logic [1:0] OP_IDLE = 2'd0;
  localparam logic [1:0] OP_GEN  = 2'd1;
  localparam logic [1:0] OP_SEED = 2'd2;
  localparam logic [31:0] VERSION = 32'h0000_46BC;

  logic [1:0]       op_q;
  logic [CW-1:0]    cnt_q;
  logic             mode_wide_q, gen_wide_q;
  logic             ie_glb_q;
  logic [1:0]       ie_mask_q;
  logic [1:0]       ist_q;
  logic [7:0][31:0] words_q;
  logic [31:0]      reseed_n_q, units_q, lfsr_q, key_q;

  wire wr      = bus_en & bus_we;
  wire busy    = op_q != OP_IDLE;
  wire cmd_wr  = wr && bus_addr == 8'h00 && !busy &&
                 (bus_wdata[1:0] == OP_GEN || bus_wdata[1:0] == OP_SEED);
  wire gen_done  = op_q == OP_GEN && cnt_q == (gen_wide_q ? CW'(7) : CW'(3));
  wire seed_done = op_q == OP_SEED && cnt_q == CW'(SEED_CYCLES - 1);
  wire [31:0] units_next = units_q + (gen_wide_q ? 32'd2 : 32'd1);
  wire need_reseed = reseed_n_q != 32'd0 && units_next >= reseed_n_q;
  wire [31:0] lfsr_next = {lfsr_q[30:0], lfsr_q[31] ^ lfsr_q[21] ^ lfsr_q[1] ^ lfsr_q[0]};
  wire [31:0] mix = (lfsr_q ^ {key_q[18:0], key_q[31:19]}) + {{(32-CW){1'b0}}, cnt_q};
  wire [31:0] key_next = key_q ^ {lfsr_q[6:0], lfsr_q[31:7]};
  wire [1:0] ist_set = {seed_done, gen_done};

  assign irq = ie_glb_q & |(ie_mask_q & ist_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q        <= OP_IDLE;
      cnt_q       <= '0;
      mode_wide_q <= 1'b0;
      gen_wide_q  <= 1'b0;
      ie_glb_q    <= 1'b0;
      ie_mask_q   <= 2'b00;
      words_q     <= '0;
      reseed_n_q  <= '0;
      units_q     <= '0;
      lfsr_q      <= LFSR_INIT;
      key_q       <= KEY_INIT;
    end else begin
      lfsr_q <= lfsr_next;
      if (cmd_wr) begin
        op_q       <= bus_wdata[1:0];
        cnt_q      <= '0;
        gen_wide_q <= mode_wide_q;
      end else if (op_q == OP_GEN) begin
        words_q[cnt_q[2:0]] <= mix;
        if (gen_done) begin
          cnt_q <= '0;
          if (need_reseed) begin
            op_q    <= OP_SEED;
            units_q <= '0;
          end else begin
            op_q    <= OP_IDLE;
            units_q <= units_next;
          end
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end else if (op_q == OP_SEED) begin
        key_q <= key_next;
        if (seed_done) begin
          op_q  <= OP_IDLE;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
      if (wr && bus_addr == 8'h08) mode_wide_q <= bus_wdata[3];
      if (wr && bus_addr == 8'h10) begin
        ie_glb_q  <= bus_wdata[31];
        ie_mask_q <= bus_wdata[1:0];
      end
      if (wr && bus_addr == 8'h60) begin
        reseed_n_q <= bus_wdata;
        units_q    <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ist_q <= {1'b0, RDY_AT_RESET};
    else if (wr && bus_addr == 8'h14) ist_q <= (ist_q & ~bus_wdata[1:0]) | ist_set;
    else ist_q <= ist_q | ist_set;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr[7:5] == 3'b001) bus_rdata = words_q[bus_addr[4:2]];
    else case (bus_addr)
      8'h00: bus_rdata = {30'd0, op_q};
      8'h08: bus_rdata = {28'd0, mode_wide_q, 3'd0};
      8'h10: bus_rdata = {ie_glb_q, 29'd0, ie_mask_q};
      8'h14: bus_rdata = {30'd0, ist_q};
      8'h60: bus_rdata = reseed_n_q;
      8'hF0: bus_rdata = VERSION;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/trng_core_chk.sv
module trng_core_chk (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_en,
  input logic             bus_we,
  input logic [7:0]       bus_addr,
  input logic [31:0]      bus_wdata,
  input logic [31:0]      bus_rdata,
  input logic             irq,
  input logic             ie_glb_q,
  input logic [1:0]       op_q,
  input logic [1:0]       ist_q,
  input logic             gen_done,
  input logic             seed_done,
  input logic             gen_wide_q,
  input logic [7:0][31:0] words_q
);
  p_irq_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ie_glb_q);

  p_w1c_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && bus_addr == 8'h14 && bus_wdata[0] && !gen_done) |=> !ist_q[0]);

  p_half_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == 2'd1 && !gen_wide_q) |=> $stable(words_q[7:4]));

  p_version_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 8'hF0) |-> bus_rdata == 32'h0000_46BC);

  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == 2'd2 && !seed_done) |=> op_q == 2'd2);
endmodule

bind trng_core trng_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .irq(irq), .ie_glb_q(ie_glb_q), .op_q(op_q), .ist_q(ist_q),
  .gen_done(gen_done), .seed_done(seed_done), .gen_wide_q(gen_wide_q),
  .words_q(words_q)
);

// File: tb/trng_core_test.sv
module trng_core_test;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  trng_core uut (.clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
                 .bus_addr(bus_addr), .bus_wdata(bus_wdata),
                 .bus_rdata(bus_rdata), .irq(irq));

  always #(CLK_NS/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 400; i++) begin
      rd(8'h00, v);
      if (v == 0) return;
    end
    chk(1'b0, "R1 idle timeout", v, 32'd0);
  endtask

  task automatic run(input logic [31:0] code);
    wr(8'h00, code);
    wait_idle();
  endtask

  task automatic snap(output logic [31:0] s [8]);
    for (int i = 0; i < 8; i++) rd(8'h20 + 8'(4*i), s[i]);
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] a [8];
    logic [31:0] b [8];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R5 reset state
    rd(8'h14, v); chk(v == 32'd1, "R5 status after reset", v, 32'd1);
    rd(8'h00, v); chk(v == 0, "R5 ctrl after reset", v, 0);
    chk(irq == 1'b0, "R5 irq after reset", {31'd0, irq}, 0);
    snap(a);
    for (int i = 0; i < 8; i++) chk(a[i] == 0, "R5 word zero", a[i], 0);

    // R4 write 0 no effect, write 1 clears
    wr(8'h14, 32'd0); rd(8'h14, v); chk(v == 32'd1, "R4 write0 keeps", v, 1);
    wr(8'h14, 32'd1); rd(8'h14, v); chk(v == 32'd0, "R4 w1c clears", v, 0);

    // R7 version
    rd(8'hF0, v); chk(v == 32'h46BC, "R7 version", v, 32'h46BC);
    wr(8'hF0, 32'hFFFF_FFFF);
    rd(8'hF0, v); chk(v == 32'h46BC, "R7 version write ignored", v, 32'h46BC);

    // R2 R10 256-bit generation
    wr(8'h08, 32'h8); rd(8'h08, v); chk(v == 32'h8, "R2 mode readback", v, 32'h8);
    snap(a);
    run(1);
    snap(b);
    for (int i = 0; i < 8; i++) chk(b[i] != a[i], "R10 wide word changed", b[i], a[i]);
    rd(8'h14, v); chk(v == 32'd1, "R4 ready after gen", v, 1);
    wr(8'h14, 32'd3);

    // R3 R2 128-bit generation
    wr(8'h08, 32'h0);
    snap(a); run(1); snap(b);
    for (int i = 0; i < 4; i++) chk(b[i] != a[i], "R2 narrow low word changed", b[i], a[i]);
    for (int i = 4; i < 8; i++) chk(b[i] == a[i], "R3 narrow upper word held", b[i], a[i]);
    wr(8'h14, 32'd3);

    // R1 code 3 ignored
    wr(8'h00, 32'd3);
    rd(8'h00, v); chk(v == 0, "R1 code3 ignored ctrl", v, 0);
    repeat (20) @(negedge clk);
    rd(8'h14, v); chk(v == 0, "R1 code3 no status", v, 0);

    // R8 R1 command while busy
    wr(8'h00, 32'd2);
    wr(8'h00, 32'd1);
    rd(8'h00, v); chk(v == 32'd2, "R1 busy readback seed", v, 2);
    wait_idle();
    rd(8'h14, v); chk(v == 32'd2, "R8 gen during seed ignored", v, 2);
    wr(8'h14, 32'd3);

    // R9 auto reseed sweep
    for (int m = 0; m < 2; m++) begin
      for (int n = 1; n <= 4; n++) begin
        int units;
        units = 0;
        wr(8'h08, m ? 32'h8 : 32'h0);
        wr(8'h60, n);
        for (int g = 0; g < 6; g++) begin
          bit exp_rs;
          units += m ? 2 : 1;
          exp_rs = units >= n;
          if (exp_rs) units = 0;
          run(1);
          rd(8'h14, v);
          chk(v == {30'd0, exp_rs, 1'b1}, "R9 reseed after gen", v, {30'd0, exp_rs, 1'b1});
          wr(8'h14, 32'd3);
        end
      end
    end
    wr(8'h60, 32'd0);
    wr(8'h08, 32'h0);
    for (int g = 0; g < 3; g++) begin
      run(1);
      rd(8'h14, v); chk(v == 32'd1, "R9 N=0 no reseed", v, 1);
      wr(8'h14, 32'd3);
    end

    // R6 interrupt sweep
    for (int s = 0; s < 4; s++) begin
      run(2); run(1);
      wr(8'h14, 32'(~s & 3));
      rd(8'h14, v); chk(v == 32'(s), "R4 selective clear", v, 32'(s));
      for (int e = 0; e < 8; e++) begin
        logic exp_irq;
        wr(8'h10, {e[2], 29'd0, e[1:0]});
        exp_irq = e[2] & |(e[1:0] & s[1:0]);
        rd(8'h10, v);
        chk(irq == exp_irq, "R6 irq gating", {31'd0, irq}, {31'd0, exp_irq});
      end
      wr(8'h10, 32'd0);
      wr(8'h14, 32'd3);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule